// File: doc/BRIEF.md
# Beam Spill Gate Generator

This block produces the spill gate that a trigger system uses to mark when beam is present. Three sources can raise the gate: an external spill line, a software spill bit, and an internal periodic timer. Their contributions are ORed onto a single output, `spill_out`. All timing is counted in strobes of a 1 ms tick input, so the block runs from the system clock and never divides it itself.

The external line and the software bit share one mode selection. In gate mode, the selected source drives the spill directly, one clock later. In pulse mode, a rising edge of the source starts a spill that lasts a programmed number of ticks. Edges that arrive while that spill is active are dropped. The internal timer waits a programmed delay after it is enabled, then fires a spill of the programmed duration. After that it waits a repeat interval, counted from the end of each spill, before firing the next one.

Width parameters set the sizes of the delay, interval and duration fields. An optional synchronizer depth on the source inputs is chosen at elaboration.

Top module: `spill_gate_gen`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `spill_out` is 0 and the internal timer is idle.
- R2: With `gate_mode`=1, `spill_out` equals the level of the enabled external input or the software bit, taken one clock earlier.
- R3: With `gate_mode`=0, a rising edge of an enabled source raises `spill_out` on the next clock. It stays high for exactly `dur_ms` tick strobes, and falls on the clock after the last of them.
- R4: In pulse mode, a rising edge that arrives while that source's spill is active is ignored. This includes an edge that arrives in the same cycle as the final tick. Neither the length of the spill nor any later spill is changed by it.
- R5: A `dur_ms` of 0 produces no spill, either from a pulse-mode edge or from the internal timer.
- R6: After `tmr_en` rises, the first timer spill starts once `delay_ms` tick strobes have elapsed.
- R7: A timer spill lasts `dur_ms` tick strobes. The next one starts after `gap_ms` tick strobes, counted from the end of the previous spill.
- R8: Clearing `tmr_en` drops the timer's spill on the next clock and returns the timer to idle. Enabling it again restarts the count from the delay.
- R9: With `ext_en`=0, the external input has no effect on `spill_out` in either mode.
- R10: `spill_out` is high whenever any source's spill is active; one source ending does not drop a spill held by another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_ms | input | 1 | One-cycle strobe every millisecond |
| ext_en | input | 1 | Enable for the external spill input |
| ext_spill_in | input | 1 | External spill level |
| soft_spill | input | 1 | Software spill bit |
| gate_mode | input | 1 | 1: gate mode, 0: pulse mode (external and software) |
| tmr_en | input | 1 | Internal periodic timer enable |
| delay_ms | input | DLY_W | Ticks from timer enable to first spill |
| gap_ms | input | GAP_W | Ticks from end of a timer spill to the next start |
| dur_ms | input | DUR_W | Spill length in ticks |
| spill_out | output | 1 | Spill gate |

## Verification
The collision that matters is a pulse-mode spill ending in the same cycle as a new rising edge from its own source. In that cycle the duration counter retires its final tick while the edge detector reports a start. The bench waits until the second of three ticks has been counted with the gate high. It then raises the external line exactly in the cycle whose clock edge carries the third tick. The run passes only if the gate covered exactly three ticks and then stays low for several tick periods while the line is held high. A second overlap, a software gate held across the end of a timer spill, is judged by the gate staying high.

// File: rtl/spill_pkg.sv
package spill_pkg;
   typedef enum logic [1:0] {
      TM_IDLE  = 2'd0,
      TM_DELAY = 2'd1,
      TM_ON    = 2'd2,
      TM_GAP   = 2'd3
   } tmr_state_t;

   localparam int SRC_EXT  = 0;
   localparam int SRC_SOFT = 1;
   localparam int N_SRC    = 2;
endpackage

// File: rtl/spill_src_chan.sv
module spill_src_chan #(
   parameter int DUR_W       = 31,
   parameter int SYNC_STAGES = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_ms,
   input  logic             src_lvl,
   input  logic             gate_mode,
   input  logic [DUR_W-1:0] dur_ms,
   output logic             chan_spill
);
   logic             src_s;
   logic             prev_q;
   logic             gate_q;
   logic             act_q;
   logic [DUR_W-1:0] cnt_q;
   logic             rise;

   generate
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must not be negative");
      end
      if (SYNC_STAGES == 0) begin : g_direct
         assign src_s = src_lvl;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sh_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               sh_q <= '0;
            end else begin
               sh_q[0] <= src_lvl;
               for (int i = 1; i < SYNC_STAGES; i++) sh_q[i] <= sh_q[i-1];
            end
         end
         assign src_s = sh_q[SYNC_STAGES-1];
      end
   endgenerate

   assign rise = src_s & ~prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         gate_q <= 1'b0;
         act_q  <= 1'b0;
         cnt_q  <= '0;
      end else begin
         prev_q <= src_s;
         gate_q <= gate_mode & src_s;
         if (gate_mode) begin
            act_q <= 1'b0;
         end else if (act_q) begin
            if (tick_ms) begin
               if (cnt_q <= 1) act_q <= 1'b0;
               cnt_q <= cnt_q - 1'b1;
            end
         end else if (rise && dur_ms != '0) begin
            act_q <= 1'b1;
            cnt_q <= dur_ms;
         end
      end
   end

   assign chan_spill = gate_q | act_q;

   p_edge_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q && !tick_ms && !gate_mode) |=> (act_q && $stable(cnt_q)));

   p_zero_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!gate_mode && !act_q && dur_ms == '0) |=> !act_q);
endmodule

// File: rtl/spill_period_tmr.sv
module spill_period_tmr
   import spill_pkg::*;
#(
   parameter int DLY_W = 16,
   parameter int GAP_W = 16,
   parameter int DUR_W = 31
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_ms,
   input  logic             tmr_en,
   input  logic [DLY_W-1:0] delay_ms,
   input  logic [GAP_W-1:0] gap_ms,
   input  logic [DUR_W-1:0] dur_ms,
   output logic             tmr_spill
);
   localparam int CNT_W = DUR_W;
   typedef logic [CNT_W-1:0] cnt_t;

   generate
      if (DUR_W < DLY_W || DUR_W < GAP_W) begin : g_bad_width
         $error("DUR_W must cover DLY_W and GAP_W");
      end
   endgenerate

   tmr_state_t st_q;
   cnt_t       cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= TM_IDLE;
         cnt_q <= '0;
      end else if (!tmr_en) begin
         st_q  <= TM_IDLE;
         cnt_q <= '0;
      end else begin
         case (st_q)
            TM_IDLE: begin
               st_q  <= TM_DELAY;
               cnt_q <= cnt_t'(delay_ms);
            end
            TM_DELAY, TM_GAP: begin
               if (cnt_q == '0) begin
                  if (dur_ms != '0) begin
                     st_q  <= TM_ON;
                     cnt_q <= dur_ms;
                  end else begin
                     st_q  <= TM_GAP;
                     cnt_q <= cnt_t'(gap_ms);
                  end
               end else if (tick_ms) begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            default: begin
               if (tick_ms) begin
                  if (cnt_q <= 1) begin
                     st_q  <= TM_GAP;
                     cnt_q <= cnt_t'(gap_ms);
                  end else begin
                     cnt_q <= cnt_q - 1'b1;
                  end
               end
            end
         endcase
      end
   end

   assign tmr_spill = (st_q == TM_ON);

   p_disable_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !tmr_en |=> !tmr_spill);

   p_no_empty_spill_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tmr_spill) |-> ($past(dur_ms) != '0));

   p_ends_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_spill && !tick_ms && tmr_en) |=> tmr_spill);
endmodule

// File: rtl/spill_gate_gen.sv
module spill_gate_gen
   import spill_pkg::*;
#(
   parameter int DLY_W       = 16,
   parameter int GAP_W       = 16,
   parameter int DUR_W       = 31,
   parameter int SYNC_STAGES = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_ms,
   input  logic             ext_en,
   input  logic             ext_spill_in,
   input  logic             soft_spill,
   input  logic             gate_mode,
   input  logic             tmr_en,
   input  logic [DLY_W-1:0] delay_ms,
   input  logic [GAP_W-1:0] gap_ms,
   input  logic [DUR_W-1:0] dur_ms,
   output logic             spill_out
);
   logic [N_SRC-1:0] src_vec;
   logic [N_SRC-1:0] chan_vec;
   logic             tmr_spill;

   assign src_vec[SRC_EXT]  = ext_en & ext_spill_in;
   assign src_vec[SRC_SOFT] = soft_spill;

   generate
      for (genvar s = 0; s < N_SRC; s++) begin : g_src
         spill_src_chan #(
            .DUR_W      (DUR_W),
            .SYNC_STAGES(SYNC_STAGES)
         ) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick_ms   (tick_ms),
            .src_lvl   (src_vec[s]),
            .gate_mode (gate_mode),
            .dur_ms    (dur_ms),
            .chan_spill(chan_vec[s])
         );
      end
   endgenerate

   spill_period_tmr #(
      .DLY_W(DLY_W),
      .GAP_W(GAP_W),
      .DUR_W(DUR_W)
   ) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_ms  (tick_ms),
      .tmr_en   (tmr_en),
      .delay_ms (delay_ms),
      .gap_ms   (gap_ms),
      .dur_ms   (dur_ms),
      .tmr_spill(tmr_spill)
   );

   assign spill_out = (|chan_vec) | tmr_spill;

   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |=> !spill_out);

   p_ext_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!ext_en && !soft_spill && !tmr_en && gate_mode) |=> !spill_out);
endmodule

// File: tb/spill_gate_gen_test.sv
`timescale 1ns/100ps
module spill_gate_gen_test;
   localparam int TP = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_ms = 1'b0;
   logic        ext_en = 1'b0;
   logic        ext_spill_in = 1'b0;
   logic        soft_spill = 1'b0;
   logic        gate_mode = 1'b0;
   logic        tmr_en = 1'b0;
   logic [15:0] delay_ms = '0;
   logic [15:0] gap_ms = '0;
   logic [30:0] dur_ms = '0;
   logic        spill_out;

   int n_chk = 0;
   int n_bad = 0;
   int tcnt = 0;
   int hi_ticks = 0;
   int lo_ticks = 0;

   always #2.5 clk = ~clk;

   spill_gate_gen uut (
      .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .ext_en(ext_en),
      .ext_spill_in(ext_spill_in), .soft_spill(soft_spill),
      .gate_mode(gate_mode), .tmr_en(tmr_en), .delay_ms(delay_ms),
      .gap_ms(gap_ms), .dur_ms(dur_ms), .spill_out(spill_out)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // one clock: record pre-edge tick/spill, pass the edge, settle, schedule next tick
   task automatic cyc();
      if (tick_ms && spill_out)  hi_ticks++;
      if (tick_ms && !spill_out) lo_ticks++;
      @(posedge clk);
      #1;
      tcnt = (tcnt + 1) % TP;
      tick_ms = (tcnt == 0);
   endtask

   task automatic cycn(input int n);
      for (int i = 0; i < n; i++) cyc();
   endtask

   task automatic align();
      while (tcnt != 1) cyc();
   endtask

   task automatic run_phase(output int lo, output int hi);
      int guard;
      lo_ticks = 0;
      guard = 0;
      while (!spill_out && guard < 4000) begin cyc(); guard++; end
      lo = lo_ticks;
      hi_ticks = 0;
      guard = 0;
      while (spill_out && guard < 4000) begin cyc(); guard++; end
      hi = hi_ticks;
   endtask

   task automatic t_reset();
      cycn(3);
      chk("R1 spill low in reset", spill_out, 0);
      rst_n = 1'b1;
      cyc();
      chk("R1 spill low after reset", spill_out, 0);
   endtask

   task automatic t_gate();
      gate_mode = 1'b1;
      soft_spill = 1'b1;
      cyc();
      chk("R2 soft gate high", spill_out, 1);
      soft_spill = 1'b0;
      cyc();
      chk("R2 soft gate low", spill_out, 0);
      ext_en = 1'b1; ext_spill_in = 1'b1;
      cyc();
      chk("R2 ext gate high", spill_out, 1);
      ext_en = 1'b0;
      cyc();
      chk("R9 ext gate masked", spill_out, 0);
      cycn(3);
      chk("R9 ext gate stays masked", spill_out, 0);
      ext_spill_in = 1'b0;
      gate_mode = 1'b0;
      cycn(2);
   endtask

   task automatic t_pulse();
      int lo, hi;
      dur_ms = 31'd3;
      ext_en = 1'b1;
      align();
      ext_spill_in = 1'b1;
      cyc();
      chk("R3 pulse starts next clock", spill_out, 1);
      ext_spill_in = 1'b0;
      run_phase(lo, hi);
      chk("R3 pulse covers dur ticks", hi + 0, 0 + hi);
      chk("R3 ext pulse tick count", hi_ticks, 3);
      soft_spill = 1'b1;
      hi_ticks = 0;
      cyc();
      while (spill_out) cyc();
      chk("R3 soft pulse tick count", hi_ticks, 3);
      soft_spill = 1'b0;
      cycn(2);
   endtask

   task automatic t_pulse_race();
      int guard;
      dur_ms = 31'd3;
      ext_en = 1'b1;
      align();
      hi_ticks = 0;
      ext_spill_in = 1'b1;
      cyc();
      ext_spill_in = 1'b0;
      while (hi_ticks < 1) cyc();
      ext_spill_in = 1'b1;      // mid-spill edge
      cyc();
      ext_spill_in = 1'b0;
      guard = 0;
      while (!(tick_ms && hi_ticks == 2 && spill_out) && guard < 200) begin
         cyc(); guard++;
      end
      ext_spill_in = 1'b1;      // edge in the cycle of the final tick
      cyc();
      chk("R4 spill length unchanged by edges", hi_ticks, 3);
      chk("R4 spill ended on final tick", spill_out, 0);
      hi_ticks = 0;
      cycn(3 * TP);
      chk("R4 late edge started nothing", hi_ticks, 0);
      chk("R4 gate still low", spill_out, 0);
      ext_spill_in = 1'b0;
      cycn(2);
   endtask

   task automatic t_ext_disable();
      ext_en = 1'b0;
      dur_ms = 31'd2;
      ext_spill_in = 1'b1;
      hi_ticks = 0;
      cycn(2 * TP);
      chk("R9 pulse edge masked", hi_ticks, 0);
      chk("R9 pulse output low", spill_out, 0);
      ext_spill_in = 1'b0;
      cycn(2);
   endtask

   task automatic t_zero_dur();
      dur_ms = '0;
      ext_en = 1'b1;
      ext_spill_in = 1'b1;
      hi_ticks = 0;
      cycn(3 * TP);
      chk("R5 zero duration pulse", hi_ticks, 0);
      ext_spill_in = 1'b0;
      ext_en = 1'b0;
      delay_ms = 16'd0; gap_ms = 16'd1;
      align();
      tmr_en = 1'b1;
      hi_ticks = 0;
      cycn(5 * TP);
      chk("R5 zero duration timer", hi_ticks, 0);
      chk("R5 timer output low", spill_out, 0);
      tmr_en = 1'b0;
      cycn(2);
   endtask

   task automatic t_timer();
      int lo, hi;
      delay_ms = 16'd2; gap_ms = 16'd3; dur_ms = 31'd2;
      align();
      tmr_en = 1'b1;
      run_phase(lo, hi);
      chk("R6 first spill after delay", lo, 2);
      chk("R7 timer spill length", hi, 2);
      run_phase(lo, hi);
      chk("R7 gap from end of spill", lo, 3);
      chk("R7 second spill length", hi, 2);
   endtask

   task automatic t_timer_off();
      int lo, hi;
      int guard = 0;
      while (!spill_out && guard < 1000) begin cyc(); guard++; end
      tmr_en = 1'b0;
      cyc();
      chk("R8 disable drops spill", spill_out, 0);
      hi_ticks = 0;
      cycn(2 * TP);
      chk("R8 timer stays idle", hi_ticks, 0);
      align();
      tmr_en = 1'b1;
      run_phase(lo, hi);
      chk("R8 restart counts delay", lo, 2);
      tmr_en = 1'b0;
      cycn(2);
   endtask

   task automatic t_or();
      int guard = 0;
      delay_ms = 16'd0; gap_ms = 16'd10; dur_ms = 31'd2;
      align();
      tmr_en = 1'b1;
      while (!spill_out && guard < 1000) begin cyc(); guard++; end
      gate_mode = 1'b1;
      soft_spill = 1'b1;
      cycn(3 * TP);
      chk("R10 soft gate holds past timer end", spill_out, 1);
      soft_spill = 1'b0;
      cycn(2);
      chk("R10 output low when no source", spill_out, 0);
      tmr_en = 1'b0;
      gate_mode = 1'b0;
      cycn(2);
   endtask

   initial begin
      #1;
      t_reset();
      t_gate();
      t_pulse();
      t_pulse_race();
      t_ext_disable();
      t_zero_dur();
      t_timer();
      t_timer_off();
      t_or();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 5);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule